// File: doc/BRIEF.md
# Parallel FPGA Configuration Master

This block loads a bitstream into a slave FPGA through its parallel configuration port, acting as the master of that port. After a `go` pulse it resets the slave's configuration logic with a low pulse on its reset strobe. It then selects the slave and sets the port to write, and waits for the slave's ready status. Once the slave is ready, it streams bitstream words from an upstream valid/ready source onto an 8- or 16-bit bus. The block generates the configuration clock itself.

The configuration clock is derived from the system clock. Each half period lasts `HALF_DIV` system cycles. The clock runs only while a word is loaded, so a slow source pauses the port instead of corrupting it. The slave may drop its ready status while words are moving; the block treats this as a configuration error and stops at once. After the last word it issues a fixed number of startup clocks. It keeps clocking until the slave reports that it is live, or until a timeout expires. Exactly one sticky status flag tells the outcome: success, error, ready timeout or live timeout.

Top module: `cfg_master`

## Requirements
- R1: Out of reset and whenever `busy` is low, `slv_reset_n`, `slv_sel_n` and `slv_wr_n` are high, while `slv_clk` and `bs_ready` are low.
- R2: A `go` pulse in idle raises `busy` on the next cycle and drives `slv_reset_n` low for exactly `PROG_CYCLES` system cycles. A `go` pulse while `busy` is high is ignored.
- R3: Once `slv_reset_n` is released, `slv_sel_n` and `slv_wr_n` are low (0 = write). No rising `slv_clk` edge occurs and no word is accepted until `slv_ready` is high. If `slv_ready` stays low for `RDY_TIMEOUT` cycles, `tmo_ready` is set and `busy` falls.
- R4: A word is put on `slv_data` while `slv_clk` is low. `slv_clk` rises `HALF_DIV` cycles later and stays high for `HALF_DIV` cycles. `slv_data` does not change while `slv_clk` is high or at its rising edge.
- R5: When `wide16`=1 each 16-bit word goes out whole. When `wide16`=0 only bits 7:0 are used and bus bits 15:8 are zero. Words go out in arrival order with no bit reordering.
- R6: `bs_ready` is high only while `slv_clk` is parked low with no word loaded. `slv_clk` stays low while no word is available. Exactly `nwords` words are accepted.
- R7: If `slv_ready` goes low while words are being sent, no further word is clocked or accepted, `cfg_err` is set and `busy` falls.
- R8: After the last word, at least `STARTUP_CLKS` rising `slv_clk` edges are issued before `slv_live` is honoured. An early `slv_live` does not shorten this.
- R9: `cfg_ok` is set and `busy` falls when `slv_live` is seen high after the startup clocks.
- R10: If `slv_live` stays low for `LIVE_TIMEOUT` cycles after the startup clocks, `tmo_live` is set and `busy` falls.
- R11: At most one status flag is high at a time. No flag is high while `busy` is high, and a flag holds until the next accepted `go`.
- R12: With `nwords`=0 no word is accepted, and the block goes straight from slave ready to startup clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse for a configuration attempt |
| wide16 | input | 1 | Bus width, 1 = 16 bits, 0 = 8 bits; latched on `go` |
| nwords | input | 32 | Number of bus words to send; latched on `go` |
| bs_data | input | 16 | Bitstream word from the source |
| bs_valid | input | 1 | Source word valid |
| bs_ready | output | 1 | Block accepts a word this cycle |
| slv_clk | output | 1 | Configuration clock to the slave |
| slv_data | output | 16 | Configuration data bus |
| slv_reset_n | output | 1 | Active-low reset of the slave configuration logic |
| slv_sel_n | output | 1 | Active-low slave select |
| slv_wr_n | output | 1 | Direction, 0 = write |
| slv_ready | input | 1 | Slave ready status; low during transfer means error |
| slv_live | input | 1 | Slave configured and live |
| busy | output | 1 | Attempt in progress |
| cfg_ok | output | 1 | Sticky success flag |
| cfg_err | output | 1 | Sticky error flag (ready lost during transfer) |
| tmo_ready | output | 1 | Sticky timeout flag waiting for ready |
| tmo_live | output | 1 | Sticky timeout flag waiting for live |

## Verification
The hardest situations to reach are the slave losing ready just after a given word has been clocked in, and the slave reporting live before the startup clocks have run. Both have to land on exact points of the transfer. The bench models the slave. It counts the rising clock edges it captures, drops ready right after the k-th capture, and raises live as soon as the last word is captured. From the captured data and the edges counted after the last word, it checks that the transfer stopped at word k, and that every startup clock was still issued. Random source gaps force the clock to pause on many words.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;
    localparam int CFGM_BUS_W    = 16;
    localparam int CFGM_NARROW_W = 8;
    localparam int CFGM_CNT_W    = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WRDY,
        ST_DATA,
        ST_START,
        ST_WLIVE
    } cfgm_state_e;

    typedef struct packed {
        cfgm_state_e              st;
        logic                     sclk;
        logic [CFGM_BUS_W-1:0]    bus;
        logic                     loaded;
        logic                     wide;
        logic [CFGM_CNT_W-1:0]    remain;
        logic [CFGM_CNT_W-1:0]    cnt;
        logic                     ok;
        logic                     err;
        logic                     tmo_rdy;
        logic                     tmo_live;
    } cfgm_regs_t;
endpackage

// File: rtl/cfgm_tick.sv
module cfgm_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HW = $clog2(HALF_DIV + 1);

    logic [HW-1:0] cnt_d, cnt_q;

    // One tick per half period of the configuration clock while running.
    always_comb begin
        tick  = run && (cnt_q == HW'(HALF_DIV - 1));
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfgm_seq.sv
module cfgm_seq
    import cfgm_pkg::*;
#(
    parameter int PROG_CYCLES  = 64,
    parameter int RDY_TIMEOUT  = 100000,
    parameter int LIVE_TIMEOUT = 100000,
    parameter int STARTUP_CLKS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic                  wide16,
    input  logic [CFGM_CNT_W-1:0] nwords,
    input  logic [CFGM_BUS_W-1:0] bs_data,
    input  logic                  bs_valid,
    output logic                  bs_ready,
    input  logic                  tick,
    output logic                  run,
    output logic                  slv_clk,
    output logic [CFGM_BUS_W-1:0] slv_data,
    output logic                  slv_reset_n,
    output logic                  slv_sel_n,
    output logic                  slv_wr_n,
    input  logic                  slv_ready,
    input  logic                  slv_live,
    output logic                  busy,
    output logic                  cfg_ok,
    output logic                  cfg_err,
    output logic                  tmo_ready,
    output logic                  tmo_live
);
    localparam int CW = CFGM_CNT_W;
    localparam int UPPER_W = CFGM_BUS_W - CFGM_NARROW_W;

    cfgm_regs_t d, q;
    logic       selected;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.st       = ST_PROG;
                    d.cnt      = '0;
                    d.wide     = wide16;
                    d.remain   = nwords;
                    d.sclk     = 1'b0;
                    d.loaded   = 1'b0;
                    d.ok       = 1'b0;
                    d.err      = 1'b0;
                    d.tmo_rdy  = 1'b0;
                    d.tmo_live = 1'b0;
                end
            end
            ST_PROG: begin
                if (q.cnt == CW'(PROG_CYCLES - 1)) begin
                    d.st  = ST_WRDY;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_WRDY: begin
                if (slv_ready) begin
                    d.cnt = '0;
                    d.st  = (q.remain == '0) ? ST_START : ST_DATA;
                end else if (q.cnt == CW'(RDY_TIMEOUT - 1)) begin
                    d.tmo_rdy = 1'b1;
                    d.st      = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_DATA: begin
                if (!slv_ready) begin
                    d.err    = 1'b1;
                    d.st     = ST_IDLE;
                    d.sclk   = 1'b0;
                    d.loaded = 1'b0;
                end else if (!q.loaded) begin
                    if (bs_valid) begin
                        d.bus    = q.wide ? bs_data
                                          : {{UPPER_W{1'b0}}, bs_data[CFGM_NARROW_W-1:0]};
                        d.loaded = 1'b1;
                    end
                end else if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk   = 1'b0;
                        d.loaded = 1'b0;
                        d.remain = q.remain - 1'b1;
                        if (q.remain == CW'(1)) begin
                            d.st  = ST_START;
                            d.cnt = '0;
                        end
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    d.sclk = !q.sclk;
                    if (q.sclk) begin
                        if (q.cnt == CW'(STARTUP_CLKS - 1)) begin
                            d.st  = ST_WLIVE;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_WLIVE: begin
                if (slv_live) begin
                    d.ok   = 1'b1;
                    d.st   = ST_IDLE;
                    d.sclk = 1'b0;
                end else if (q.cnt == CW'(LIVE_TIMEOUT - 1)) begin
                    d.tmo_live = 1'b1;
                    d.st       = ST_IDLE;
                    d.sclk     = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                    if (tick) d.sclk = !q.sclk;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        selected    = (q.st == ST_WRDY) || (q.st == ST_DATA) ||
                      (q.st == ST_START) || (q.st == ST_WLIVE);
        run         = ((q.st == ST_DATA) && q.loaded) ||
                      (q.st == ST_START) || (q.st == ST_WLIVE);
        bs_ready    = (q.st == ST_DATA) && !q.loaded;
        slv_clk     = q.sclk;
        slv_data    = q.bus;
        slv_reset_n = (q.st != ST_PROG);
        slv_sel_n   = !selected;
        slv_wr_n    = !selected;
        busy        = (q.st != ST_IDLE);
        cfg_ok      = q.ok;
        cfg_err     = q.err;
        tmo_ready   = q.tmo_rdy;
        tmo_live    = q.tmo_live;
    end
endmodule

// File: rtl/cfg_master.sv
module cfg_master #(
    parameter int HALF_DIV     = 2,
    parameter int PROG_CYCLES  = 64,
    parameter int RDY_TIMEOUT  = 100000,
    parameter int LIVE_TIMEOUT = 100000,
    parameter int STARTUP_CLKS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        wide16,
    input  logic [31:0] nwords,
    input  logic [15:0] bs_data,
    input  logic        bs_valid,
    output logic        bs_ready,
    output logic        slv_clk,
    output logic [15:0] slv_data,
    output logic        slv_reset_n,
    output logic        slv_sel_n,
    output logic        slv_wr_n,
    input  logic        slv_ready,
    input  logic        slv_live,
    output logic        busy,
    output logic        cfg_ok,
    output logic        cfg_err,
    output logic        tmo_ready,
    output logic        tmo_live
);
    logic run;
    logic tick;

    cfgm_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    cfgm_seq #(
        .PROG_CYCLES  (PROG_CYCLES),
        .RDY_TIMEOUT  (RDY_TIMEOUT),
        .LIVE_TIMEOUT (LIVE_TIMEOUT),
        .STARTUP_CLKS (STARTUP_CLKS)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .wide16      (wide16),
        .nwords      (nwords),
        .bs_data     (bs_data),
        .bs_valid    (bs_valid),
        .bs_ready    (bs_ready),
        .tick        (tick),
        .run         (run),
        .slv_clk     (slv_clk),
        .slv_data    (slv_data),
        .slv_reset_n (slv_reset_n),
        .slv_sel_n   (slv_sel_n),
        .slv_wr_n    (slv_wr_n),
        .slv_ready   (slv_ready),
        .slv_live    (slv_live),
        .busy        (busy),
        .cfg_ok      (cfg_ok),
        .cfg_err     (cfg_err),
        .tmo_ready   (tmo_ready),
        .tmo_live    (tmo_live)
    );
endmodule

// File: rtl/cfgm_chk.sv
module cfgm_chk #(
    parameter int PROG_CYCLES = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bs_ready,
    input logic        slv_clk,
    input logic [15:0] slv_data,
    input logic        slv_reset_n,
    input logic        slv_sel_n,
    input logic        slv_wr_n,
    input logic        busy,
    input logic        cfg_ok,
    input logic        cfg_err,
    input logic        tmo_ready,
    input logic        tmo_live
);
    logic [31:0] low_cnt;

    // Length of the current reset pulse, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_cnt <= '0;
        else if (slv_reset_n)  low_cnt <= '0;
        else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (slv_reset_n && slv_sel_n && slv_wr_n && !slv_clk && !bs_ready));

    p_reset_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_reset_n) |-> (low_cnt == 32'(PROG_CYCLES)));

    p_strobes_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_clk) |-> (!slv_sel_n && !slv_wr_n && slv_reset_n));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slv_data) |-> (!slv_clk && !$past(slv_clk)));

    p_ready_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bs_ready |-> (!slv_clk && busy));

    p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_ok, cfg_err, tmo_ready, tmo_live}));

    p_busy_no_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(cfg_ok || cfg_err || tmo_ready || tmo_live));
endmodule

bind cfg_master cfgm_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bs_ready    (bs_ready),
    .slv_clk     (slv_clk),
    .slv_data    (slv_data),
    .slv_reset_n (slv_reset_n),
    .slv_sel_n   (slv_sel_n),
    .slv_wr_n    (slv_wr_n),
    .busy        (busy),
    .cfg_ok      (cfg_ok),
    .cfg_err     (cfg_err),
    .tmo_ready   (tmo_ready),
    .tmo_live    (tmo_live)
);

// File: tb/test_cfg_master.sv
module test_cfg_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int PROG       = 6;
    localparam int RDYTO      = 120;
    localparam int LIVETO     = 200;
    localparam int STARTUP    = 8;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic        wide16 = 1'b0;
    logic [31:0] nwords = '0;
    logic [15:0] bs_data = '0;
    logic        bs_valid = 1'b0;
    logic        bs_ready;
    logic        slv_clk;
    logic [15:0] slv_data;
    logic        slv_reset_n, slv_sel_n, slv_wr_n;
    logic        slv_ready = 1'b0;
    logic        slv_live = 1'b0;
    logic        busy, cfg_ok, cfg_err, tmo_ready, tmo_live;

    cfg_master #(
        .HALF_DIV(HALF), .PROG_CYCLES(PROG), .RDY_TIMEOUT(RDYTO),
        .LIVE_TIMEOUT(LIVETO), .STARTUP_CLKS(STARTUP)
    ) i_cfg_master (
        .clk(clk), .rst_n(rst_n), .go(go), .wide16(wide16), .nwords(nwords),
        .bs_data(bs_data), .bs_valid(bs_valid), .bs_ready(bs_ready),
        .slv_clk(slv_clk), .slv_data(slv_data), .slv_reset_n(slv_reset_n),
        .slv_sel_n(slv_sel_n), .slv_wr_n(slv_wr_n), .slv_ready(slv_ready),
        .slv_live(slv_live), .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err),
        .tmo_ready(tmo_ready), .tmo_live(tmo_live)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Stimulus controls, written by the test sequence only.
    logic [15:0] src [0:63];
    int n_words = 0, valid_pct = 100, init_delay = 0, drop_at = -1;
    bit live_en = 1'b1;

    // Slave and source model state, written by the model only.
    logic [15:0] cap [0:63];
    int cap_n = 0, post_rises = 0, src_idx = 0, prog_low = 0, icnt = 0;
    int hi_len = 0, hi_bad = 0;
    bit hs_prev = 0, dropped = 0, clk_prev = 0, prog_prev = 1;

    always @(negedge clk) begin
        if (!slv_reset_n) begin
            prog_low   = prog_prev ? 1 : prog_low + 1;
            cap_n      = 0;
            post_rises = 0;
            src_idx    = 0;
            hs_prev    = 0;
            dropped    = 0;
            icnt       = 0;
            hi_len     = 0;
            hi_bad     = 0;
            slv_ready  = 1'b0;
            slv_live   = 1'b0;
            bs_valid   = 1'b0;
        end else begin
            // slave side: capture on rising configuration clock
            if (slv_clk && !clk_prev && !slv_sel_n && !slv_wr_n) begin
                if (cap_n < n_words) begin
                    cap[cap_n] = slv_data;
                    cap_n++;
                end else begin
                    post_rises++;
                end
            end
            if (slv_clk) hi_len++;
            if (!slv_clk && clk_prev) begin
                if (post_rises == 0 && !dropped && hi_len != HALF) hi_bad++;
                hi_len = 0;
            end
            if (drop_at >= 0 && cap_n >= drop_at && !dropped && slv_ready && cap_n > 0) begin
                dropped   = 1;
                slv_ready = 1'b0;
            end else if (!slv_ready && !dropped && init_delay >= 0) begin
                if (icnt >= init_delay) slv_ready = 1'b1;
                else icnt++;
            end
            if (live_en && slv_ready && cap_n == n_words) slv_live = 1'b1;
            // source side
            if (hs_prev) src_idx++;
            bs_valid = (src_idx < n_words) && (($urandom % 100) < valid_pct);
            bs_data  = (src_idx < 64) ? src[src_idx] : 16'h0;
            hs_prev  = bs_valid && bs_ready;
        end
        prog_prev = slv_reset_n;
        clk_prev  = slv_clk;
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > LIMIT) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic chk(input bit c, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!c) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input bit w, input logic [15:0] v);
        return w ? v : {8'h00, v[7:0]};
    endfunction

    // kind: 0 success, 1 ready timeout, 2 live timeout, 3 ready lost
    task automatic run_cfg(input bit w, input int n, input int vp, input int idly,
                           input int drop, input bit den, input int kind);
        int guard;
        bit poked;
        int bad;
        for (int i = 0; i < 64; i++) src[i] = 16'($urandom);
        n_words = n; valid_pct = vp; init_delay = idly; drop_at = drop; live_en = den;
        @(negedge clk);
        wide16 = w; nwords = 32'(n); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R2", "busy after go", int'(busy), 1);
        guard = 0; poked = 0;
        while (busy && guard < 60000) begin
            @(negedge clk);
            guard++;
            if (!poked && guard == 40 && busy) begin
                go = 1'b1; wide16 = !w; nwords = 32'(n + 3); poked = 1;   // R2 ignored while busy
            end else begin
                go = 1'b0;
            end
        end
        go = 1'b0;
        chk(!busy, "R2", "attempt ends", int'(busy), 0);
        repeat (4) @(negedge clk);
        chk(prog_low == PROG, "R2", "reset pulse length", prog_low, PROG);
        case (kind)
            0: begin
                chk(cfg_ok == 1'b1, "R9", "success flag", int'(cfg_ok), 1);
                chk(cap_n == n, "R6", "words clocked", cap_n, n);
                chk(src_idx == n, "R6", "words accepted", src_idx, n);
                bad = 0;
                for (int i = 0; i < n; i++)
                    if (cap[i] !== exp_word(w, src[i])) begin
                        bad++;
                        chk(0, "R5", "word value", int'(cap[i]), int'(exp_word(w, src[i])));
                    end
                chk(bad == 0, "R5", "all words in order", bad, 0);
                chk(post_rises >= STARTUP, "R8", "startup clocks", post_rises, STARTUP);
                chk(hi_bad == 0, "R4", "high phase length", hi_bad, 0);
                if (n == 0) chk(src_idx == 0 && cap_n == 0, "R12", "no words", cap_n, 0);
            end
            1: begin
                chk(tmo_ready == 1'b1, "R3", "ready timeout flag", int'(tmo_ready), 1);
                chk(cap_n == 0 && post_rises == 0, "R3", "no clock before ready",
                    cap_n + post_rises, 0);
                chk(src_idx == 0, "R3", "no word accepted", src_idx, 0);
            end
            2: begin
                chk(tmo_live == 1'b1, "R10", "live timeout flag", int'(tmo_live), 1);
                chk(cap_n == n, "R10", "all words sent first", cap_n, n);
                chk(post_rises >= STARTUP, "R8", "startup clocks before timeout", post_rises, STARTUP);
            end
            default: begin
                chk(cfg_err == 1'b1, "R7", "error flag", int'(cfg_err), 1);
                chk(cap_n == drop, "R7", "clocking stopped", cap_n, drop);
                chk(post_rises == 0, "R7", "no extra clocks", post_rises, 0);
                chk(src_idx == drop, "R7", "no word accepted after loss", src_idx, drop);
            end
        endcase
        chk($countones({cfg_ok, cfg_err, tmo_ready, tmo_live}) == 1, "R11", "one flag held",
            $countones({cfg_ok, cfg_err, tmo_ready, tmo_live}), 1);
        chk(slv_reset_n && slv_sel_n && slv_wr_n && !slv_clk && !bs_ready, "R1", "idle strobes",
            int'({slv_reset_n, slv_sel_n, slv_wr_n, slv_clk, bs_ready}), 5'b11100);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) src[i] = '0;
        repeat (5) @(negedge clk);
        chk(slv_reset_n && slv_sel_n && slv_wr_n, "R1", "strobes in reset",
            int'({slv_reset_n, slv_sel_n, slv_wr_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slv_reset_n == 1'b1, "R1", "reset strobe idle", int'(slv_reset_n), 1);
        chk(slv_sel_n == 1'b1, "R1", "select idle", int'(slv_sel_n), 1);
        chk(slv_wr_n == 1'b1, "R1", "direction idle", int'(slv_wr_n), 1);
        chk(slv_clk == 1'b0, "R1", "clock idle", int'(slv_clk), 0);
        chk(bs_ready == 1'b0, "R1", "ready idle", int'(bs_ready), 0);
        chk(busy == 1'b0, "R1", "busy idle", int'(busy), 0);
        chk(!(cfg_ok || cfg_err || tmo_ready || tmo_live), "R11", "no flag at reset", 0, 0);

        run_cfg(1'b1, 12, 100, 3, -1, 1'b1, 0);   // x16 full rate
        run_cfg(1'b0, 9, 40, 10, -1, 1'b1, 0);    // x8 with source gaps
        run_cfg(1'b1, 0, 100, 2, -1, 1'b1, 0);    // R12 empty bitstream
        run_cfg(1'b1, 1, 100, 0, -1, 1'b1, 0);    // single word
        run_cfg(1'b1, 8, 100, -1, -1, 1'b1, 1);   // ready never rises
        run_cfg(1'b0, 6, 70, 4, -1, 1'b0, 2);     // live never rises
        run_cfg(1'b1, 10, 60, 5, 4, 1'b1, 3);     // ready lost after word 4
        run_cfg(1'b0, 10, 100, 5, 1, 1'b1, 3);    // ready lost after first word
        for (int r = 0; r < 6; r++)
            run_cfg(1'($urandom), 1 + int'($urandom % 40), 20 + int'($urandom % 81),
                    int'($urandom % 30), -1, 1'b1, 0);
        finish_run();
    end
endmodule